// File: doc/BRIEF.md
# Synthesizer Load-Timing Front End

This block is the control front end of a numerically controlled oscillator. It runs from a single fast master clock and derives two clocks from one free-running counter. One is a half-rate load clock. The other is a reference clock at one eighth or one sixteenth of the master rate, chosen by a select pin; at an 80 MHz master clock this gives 10 MHz or 5 MHz, a convenient lock target for an outside loop.

A host writes a tuning word and an offset word into staging registers through a parallel port. Each word has its own active-low load strobe. A falling strobe moves the staged word into its live register, the phase-step register or the phase-offset register, but only on a master edge where the load clock is low. A small per-strobe state machine has two states:

- `LD_IDLE`: waiting for a fall. On a fall with the load clock low it commits at once and stays in `LD_IDLE`. On a fall with the load clock high it moves to `LD_WAIT_LOW` without committing.
- `LD_WAIT_LOW`: always commits on the next edge and returns to `LD_IDLE`.

A 32-bit accumulator adds the phase step every master cycle. Its sum with the offset, cut to the top 12 bits, is the output phase, which shows exactly when each transfer took effect.

Top module: `nco_load_sync`

## Requirements
- R1: `load_clk_o` is the master clock divided by two. It is 0 in the first cycle after reset and inverts on every master edge after that.
- R2: `ref_clk_o` equals bit 2 of a free-running master-cycle count when `ref_sel` is 0 (divide by 8), and bit 3 of that count when `ref_sel` is 1 (divide by 16). The count is 0 after reset.
- R3: When `freq_ld_n` falls and `load_clk_o` is 0 at the next master edge, `dphase_o` takes the staged tuning word on that edge.
- R4: When `freq_ld_n` falls and `load_clk_o` is 1 at the next master edge, the transfer happens one master cycle later.
- R5: `phase_ld_n` moves the staged offset word into `poffs_o` with the same timing as R3 and R4.
- R6: A strobe on one channel never changes the other channel's live register.
- R7: A host write stages `host_data` into the tuning word when `host_sel`=0 and into the offset word when `host_sel`=1. A write alone never changes `dphase_o` or `poffs_o`.
- R8: The accumulator adds `dphase_o` on every master edge and wraps modulo 2^32. `phase_o` is bits 31..20 of the accumulator plus `poffs_o`.
- R9: A synchronous active-high `rst` clears the divider count, the staged words, the live registers and the accumulator.
- R10: A strobe held low commits only once. A staged word written while the strobe stays low is not transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst | input | 1 | synchronous reset, active high |
| ref_sel | input | 1 | 0: reference divide by 8, 1: divide by 16 |
| host_we | input | 1 | staging write enable |
| host_sel | input | 1 | 0: tuning word, 1: offset word |
| host_data | input | 32 | staged word value |
| freq_ld_n | input | 1 | tuning-word load strobe, active low |
| phase_ld_n | input | 1 | offset-word load strobe, active low |
| ref_clk_o | output | 1 | divided reference clock |
| load_clk_o | output | 1 | half-rate load clock |
| dphase_o | output | 32 | live phase-step register |
| poffs_o | output | 32 | live phase-offset register |
| phase_o | output | 12 | truncated output phase |

## Verification
The bench drops each strobe once with the load clock low and once with it high, and samples the live register in both following cycles. A design that ignored the load-clock phase would commit early in the deferred case, and one that always waited would commit late in the direct case. It also holds a strobe low while the staged word changes; a level-triggered design would copy the second word. The output phase is compared every cycle against an accumulator kept in the bench, so a transfer landing one cycle off, or an accumulator using the staged word instead of the live one, shows up as a phase mismatch.

// File: rtl/nco_pkg.sv
package nco_pkg;
    typedef enum logic {
        LD_IDLE     = 1'b0,
        LD_WAIT_LOW = 1'b1
    } ld_state_t;

    localparam int CH_FREQ  = 0;
    localparam int CH_PHASE = 1;
    localparam int N_CH     = 2;
endpackage

// File: rtl/nco_clk_div.sv
module nco_clk_div #(
    parameter int REF_LO_LOG2 = 3,
    parameter int REF_HI_LOG2 = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_sel,
    output logic load_clk,
    output logic ref_clk
);
    localparam int CW = REF_HI_LOG2;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

    assign load_clk = cnt_q[0];
    assign ref_clk  = ref_sel ? cnt_q[REF_HI_LOG2-1] : cnt_q[REF_LO_LOG2-1];
endmodule

// File: rtl/nco_load_fsm.sv
module nco_load_fsm
    import nco_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load_clk,
    input  logic strobe_n,
    output logic commit
);
    ld_state_t st_q, st_nx;
    logic      strobe_q;
    logic      fall;

    assign fall = strobe_q & ~strobe_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= LD_IDLE;
            strobe_q <= 1'b0;
        end else begin
            st_q     <= st_nx;
            strobe_q <= strobe_n;
        end
    end

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            LD_IDLE:     if (fall && load_clk) st_nx = LD_WAIT_LOW;
            LD_WAIT_LOW: st_nx = LD_IDLE;
            default:     st_nx = LD_IDLE;
        endcase
    end

    always_comb begin
        commit = 1'b0;
        unique case (st_q)
            LD_IDLE:     commit = fall && !load_clk;
            LD_WAIT_LOW: commit = 1'b1;
            default:     commit = 1'b0;
        endcase
    end
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
    parameter int ACC_W = 32,
    parameter int OUT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] dphase,
    input  logic [ACC_W-1:0] poffs,
    output logic [OUT_W-1:0] phase
);
    localparam int SHIFT = ACC_W - OUT_W;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= acc_q + dphase;
    end

    assign sum   = acc_q + poffs;
    assign phase = OUT_W'(sum >> SHIFT);
endmodule

// File: rtl/nco_load_sync.sv
module nco_load_sync
    import nco_pkg::*;
#(
    parameter int ACC_W       = 32,
    parameter int OUT_W       = 12,
    parameter int REF_LO_LOG2 = 3,
    parameter int REF_HI_LOG2 = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_sel,
    input  logic             host_we,
    input  logic             host_sel,
    input  logic [ACC_W-1:0] host_data,
    input  logic             freq_ld_n,
    input  logic             phase_ld_n,
    output logic             ref_clk_o,
    output logic             load_clk_o,
    output logic [ACC_W-1:0] dphase_o,
    output logic [ACC_W-1:0] poffs_o,
    output logic [OUT_W-1:0] phase_o
);
    logic             load_clk;
    logic [N_CH-1:0]  strobe_n;
    logic [N_CH-1:0]  commit;
    logic [ACC_W-1:0] stage_q [N_CH];
    logic [ACC_W-1:0] live_q  [N_CH];

    assign strobe_n[CH_FREQ]  = freq_ld_n;
    assign strobe_n[CH_PHASE] = phase_ld_n;

    nco_clk_div #(
        .REF_LO_LOG2(REF_LO_LOG2),
        .REF_HI_LOG2(REF_HI_LOG2)
    ) u_div (
        .clk      (clk),
        .rst      (rst),
        .ref_sel  (ref_sel),
        .load_clk (load_clk),
        .ref_clk  (ref_clk_o)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        nco_load_fsm u_fsm (
            .clk      (clk),
            .rst      (rst),
            .load_clk (load_clk),
            .strobe_n (strobe_n[g]),
            .commit   (commit[g])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q[g] <= '0;
                live_q[g]  <= '0;
            end else begin
                if (host_we && (host_sel == 1'(g))) stage_q[g] <= host_data;
                if (commit[g])                      live_q[g]  <= stage_q[g];
            end
        end
    end

    assign load_clk_o = load_clk;
    assign dphase_o   = live_q[CH_FREQ];
    assign poffs_o    = live_q[CH_PHASE];

    nco_phase_acc #(
        .ACC_W(ACC_W),
        .OUT_W(OUT_W)
    ) u_acc (
        .clk    (clk),
        .rst    (rst),
        .dphase (live_q[CH_FREQ]),
        .poffs  (live_q[CH_PHASE]),
        .phase  (phase_o)
    );
endmodule

// File: rtl/nco_load_sync_chk.sv
module nco_load_sync_chk #(
    parameter int ACC_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             load_clk_o,
    input logic             freq_ld_n,
    input logic             phase_ld_n,
    input logic [ACC_W-1:0] dphase_o,
    input logic [ACC_W-1:0] poffs_o
);
    // R1: the load clock inverts on every edge once reset is gone
    p_lclk_toggle_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (load_clk_o != $past(load_clk_o)));

    // R3: a live tuning word only changes on an edge where the load clock was low
    p_commit_low_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (dphase_o != $past(dphase_o))) |-> !$past(load_clk_o));

    // R5: offset changes follow a fall of its own strobe one or two edges back
    p_poff_cause_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (poffs_o != $past(poffs_o))) |->
        ((!$past(phase_ld_n) && $past(phase_ld_n, 2)) ||
         (!$past(phase_ld_n, 2) && $past(phase_ld_n, 3))));

    // R7: tuning changes follow a fall of its own strobe one or two edges back
    p_freq_cause_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (dphase_o != $past(dphase_o))) |->
        ((!$past(freq_ld_n) && $past(freq_ld_n, 2)) ||
         (!$past(freq_ld_n, 2) && $past(freq_ld_n, 3))));

    // R9: the cycle after reset shows cleared live registers and a low load clock
    p_reset_clear_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dphase_o == '0 && poffs_o == '0 && !load_clk_o));
endmodule

bind nco_load_sync nco_load_sync_chk #(.ACC_W(ACC_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .load_clk_o (load_clk_o),
    .freq_ld_n  (freq_ld_n),
    .phase_ld_n (phase_ld_n),
    .dphase_o   (dphase_o),
    .poffs_o    (poffs_o)
);

// File: tb/nco_load_sync_bench.sv
`timescale 1ns/1ps
module nco_load_sync_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_sel = 1'b0;
    logic        host_we = 1'b0;
    logic        host_sel = 1'b0;
    logic [31:0] host_data = '0;
    logic        freq_ld_n = 1'b1;
    logic        phase_ld_n = 1'b1;
    logic        ref_clk_o, load_clk_o;
    logic [31:0] dphase_o, poffs_o;
    logic [11:0] phase_o;

    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 0;
    logic [31:0] cyc = '0;
    logic [31:0] m_acc = '0;
    logic [31:0] m_dph = '0;
    logic [31:0] m_poff = '0;

    always #5 clk = ~clk;

    nco_load_sync u_nco_load_sync (
        .clk(clk), .rst(rst), .ref_sel(ref_sel), .host_we(host_we),
        .host_sel(host_sel), .host_data(host_data), .freq_ld_n(freq_ld_n),
        .phase_ld_n(phase_ld_n), .ref_clk_o(ref_clk_o), .load_clk_o(load_clk_o),
        .dphase_o(dphase_o), .poffs_o(poffs_o), .phase_o(phase_o)
    );

    always @(posedge clk) begin
        if (rst) begin
            cyc   <= '0;
            m_acc <= '0;
        end else begin
            cyc   <= cyc + 1;
            m_acc <= m_acc + m_dph;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wait_lclk(input logic want);
        @(negedge clk);
        while (load_clk_o !== want) @(negedge clk);
    endtask

    task automatic stage(input logic sel, input logic [31:0] val);
        host_we = 1'b1; host_sel = sel; host_data = val;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    // R9: reset clears everything
    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(dphase_o == 0, "R9", "dphase", dphase_o, 0);
        chk(poffs_o == 0, "R9", "poffs", poffs_o, 0);
        chk(phase_o == 0, "R9", "phase", 32'(phase_o), 0);
        chk(load_clk_o == 0, "R9", "load_clk", 32'(load_clk_o), 0);
        m_dph = '0; m_poff = '0;
        rst = 1'b0;
        @(negedge clk);
        chk(load_clk_o == 1'b1, "R1", "load_clk after first edge", 32'(load_clk_o), 1);
    endtask

    // R1, R2: divider ratios for both selects
    task automatic t_dividers();
        for (int s = 0; s < 2; s++) begin
            ref_sel = s[0];
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                chk(load_clk_o == cyc[0], "R1", "load_clk", 32'(load_clk_o), 32'(cyc[0]));
                chk(ref_clk_o == (s == 1 ? cyc[3] : cyc[2]), "R2", "ref_clk",
                    32'(ref_clk_o), 32'(s == 1 ? cyc[3] : cyc[2]));
            end
        end
    endtask

    // R3, R4, R5, R6: timed transfer for either channel and either load-clock phase
    task automatic t_load(input logic ch, input logic [31:0] val, input logic lhigh);
        logic [31:0] old_v, other_v;
        string req;
        req = ch ? "R5" : (lhigh ? "R4" : "R3");
        stage(ch, val);
        wait_lclk(lhigh);
        old_v   = ch ? poffs_o : dphase_o;
        other_v = ch ? dphase_o : poffs_o;
        if (ch) phase_ld_n = 1'b0; else freq_ld_n = 1'b0;
        @(negedge clk);
        if (lhigh) begin
            chk((ch ? poffs_o : dphase_o) == old_v, req, "deferred: no early commit",
                ch ? poffs_o : dphase_o, old_v);
            @(negedge clk);
        end
        chk((ch ? poffs_o : dphase_o) == val, req, "commit cycle",
            ch ? poffs_o : dphase_o, val);
        if (ch) m_poff = val; else m_dph = val;
        chk((ch ? dphase_o : poffs_o) == other_v, "R6", "other channel untouched",
            ch ? dphase_o : poffs_o, other_v);
        @(negedge clk);
        if (ch) phase_ld_n = 1'b1; else freq_ld_n = 1'b1;
        @(negedge clk);
    endtask

    // R7: staging alone leaves the live registers alone
    task automatic t_stage_only();
        logic [31:0] d0, p0;
        d0 = dphase_o; p0 = poffs_o;
        stage(1'b0, 32'hDEAD_0001);
        stage(1'b1, 32'hDEAD_0002);
        repeat (5) @(negedge clk);
        chk(dphase_o == d0, "R7", "dphase after staging", dphase_o, d0);
        chk(poffs_o == p0, "R7", "poffs after staging", poffs_o, p0);
        chk(phase_o == 12'(((m_acc + m_poff) >> 20)), "R7", "phase tracks old words",
            32'(phase_o), (m_acc + m_poff) >> 20);
    endtask

    // R10: held-low strobe commits only once
    task automatic t_held_low();
        stage(1'b0, 32'h0000_1111);
        wait_lclk(1'b0);
        freq_ld_n = 1'b0;
        @(negedge clk);
        chk(dphase_o == 32'h0000_1111, "R10", "first commit", dphase_o, 32'h0000_1111);
        m_dph = 32'h0000_1111;
        stage(1'b0, 32'h0000_2222);
        repeat (6) @(negedge clk);
        chk(dphase_o == 32'h0000_1111, "R10", "no second commit while low",
            dphase_o, 32'h0000_1111);
        freq_ld_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(dphase_o == 32'h0000_1111, "R10", "no commit on rise",
            dphase_o, 32'h0000_1111);
    endtask

    // R8: accumulator against the bench model
    task automatic t_accum();
        t_load(1'b0, 32'h0123_4567, 1'b0);
        t_load(1'b1, 32'h8000_0000, 1'b1);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            chk(phase_o == 12'(((m_acc + m_poff) >> 20)), "R8", "phase",
                32'(phase_o), (m_acc + m_poff) >> 20);
        end
        t_load(1'b0, 32'hF000_0001, 1'b1);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            chk(phase_o == 12'(((m_acc + m_poff) >> 20)), "R8", "phase wrap",
                32'(phase_o), (m_acc + m_poff) >> 20);
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_dividers();
        t_load(1'b0, 32'hA5A5_0001, 1'b0);
        t_load(1'b0, 32'h5A5A_0002, 1'b1);
        t_load(1'b1, 32'h1234_0003, 1'b0);
        t_load(1'b1, 32'h4321_0004, 1'b1);
        t_stage_only();
        t_held_low();
        t_accum();
        t_reset();
        t_dividers();
        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule